// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block sits between the register bus and the mode controls of a flash array. It decides which single operating mode the array may be in: idle, program, erase, program-verify or erase-verify. Software writes a request register, a per-block erase-select register and a global write-lock bit. The controller turns these into a mode output and a set of per-block erase enables.

Two protection sources block the program and erase modes but leave both verify modes usable. The first is the global lock bit, set by software. The second is a sticky error flag, set by hardware. The error flag is raised by an external fault indication (a runaway or watchdog event) that arrives while a program or erase is running. It is also raised when software breaks the operating sequence. When the flag rises, any program or erase in progress is dropped in the cycle that follows. The request and erase-select registers keep their contents for inspection.

Register map (2-bit word address, `DATA_W`-bit data):
- 0: request: bit 0 program, bit 1 erase, bit 2 program-verify, bit 3 erase-verify.
- 1: erase select: bit n enables block n.
- 2: lock: bit 0 global lock.
- 3: status: bit 0 error flag, read-only.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After reset, every register reads 0, `err_o` is 0, `mode_o` is 0 (idle) and `blk_erase_en_o` is all zeros.
- R2: The mode is a combinational function of the register state, so a register write takes effect on `mode_o` right after its clock edge. The encodings are 0 idle, 1 program, 2 erase, 3 program-verify and 4 erase-verify. Program-verify wins over erase-verify when both are requested.
- R3: While the lock bit is 1, a program or erase request yields mode 0 and all erase enables 0.
- R4: While the lock bit is 1 and no program or erase request is set, verify requests still give mode 3 or 4.
- R5: `blk_erase_en_o` equals the erase-select register while the mode is 2 and is zero in every other mode. An erase-select value of 0 enables no block.
- R6: A program request enters mode 1 whatever the erase-select register holds, including 0.
- R7: A cycle with `fault_i` high while the mode is 1 or 2 sets the error flag at that clock edge, and `mode_o` leaves 1 or 2 at once. `fault_i` in any other mode is ignored.
- R8: A request write with bits 0 and 1 both 1 sets the error flag. A write to the erase-select register while the mode is 2 sets the error flag, and that write is discarded.
- R9: Raising the error flag leaves the request and erase-select registers unchanged. The request register still holds what was written, including a write that caused the error.
- R10: While the error flag is 1, program and erase requests give mode 0, and verify requests alone still give mode 3 or 4.
- R11: The error flag is sticky. Writes to address 3 do not clear it, and only `rst_ni` clears it.
- R12: While bit 0 or bit 1 of the request register is set, both verify requests are ignored. The mode is then 1, 2 or 0, never 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for `addr_i` |
| fault_i | input | 1 | Runaway/watchdog fault indication |
| mode_o | output | 3 | Active mode (0 idle, 1 program, 2 erase, 3 program-verify, 4 erase-verify) |
| blk_erase_en_o | output | NUM_BLOCKS | Per-block erase enables |
| err_o | output | 1 | Sticky error flag |

## Verification
A fault can arrive in the same cycle as a register write that changes the mode. Examples are clearing the program request, or writing the erase-select register during an erase. The bench provokes this in directed cases and in random traffic, where it drives `fault_i` together with writes. A reference model in the bench judges each such cycle against the mode that held before the edge. A fault that lands while a program or erase is still active must set the error flag, even when the same write ends that mode. When an erase-select write and a fault coincide during an erase, both sources raise the flag, and the register must still hold its old value.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_PROG  = 3'd1,
    MODE_ERASE = 3'd2,
    MODE_PVER  = 3'd3,
    MODE_EVER  = 3'd4
  } fmode_e;

  localparam logic [1:0] ADDR_REQ    = 2'd0;
  localparam logic [1:0] ADDR_BLKSEL = 2'd1;
  localparam logic [1:0] ADDR_LOCK   = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;

  localparam int REQ_W     = 4;
  localparam int BIT_PROG  = 0;
  localparam int BIT_ERASE = 1;
  localparam int BIT_PVER  = 2;
  localparam int BIT_EVER  = 3;

  typedef struct packed {
    logic ever;
    logic pver;
    logic erase;
    logic prog;
  } req_t;
endpackage

// File: rtl/flash_prot_regs.sv
module flash_prot_regs
  import flash_prot_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  erase_active_i,
  input  logic                  err_i,
  output req_t                  req_o,
  output logic [NUM_BLOCKS-1:0] blksel_o,
  output logic                  lock_o,
  output logic                  viol_o,
  output logic [DATA_W-1:0]     rdata_o
);
  req_t                  req_q;
  logic [NUM_BLOCKS-1:0] blksel_q;
  logic                  lock_q;
  logic                  wr_req, wr_blk, wr_lock;

  assign wr_req  = wr_en_i && (addr_i == ADDR_REQ);
  assign wr_blk  = wr_en_i && (addr_i == ADDR_BLKSEL);
  assign wr_lock = wr_en_i && (addr_i == ADDR_LOCK);

  // sequence violations: simultaneous program+erase, or select change mid-erase
  assign viol_o = (wr_req && wdata_i[BIT_PROG] && wdata_i[BIT_ERASE])
               || (wr_blk && erase_active_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= '0;
      blksel_q <= '0;
      lock_q   <= 1'b0;
    end else begin
      if (wr_req)                    req_q    <= req_t'(wdata_i[REQ_W-1:0]);
      if (wr_blk && !erase_active_i) blksel_q <= wdata_i[NUM_BLOCKS-1:0];
      if (wr_lock)                   lock_q   <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_REQ:    rdata_o[REQ_W-1:0]      = req_q;
      ADDR_BLKSEL: rdata_o[NUM_BLOCKS-1:0] = blksel_q;
      ADDR_LOCK:   rdata_o[0]              = lock_q;
      ADDR_STAT:   rdata_o[0]              = err_i;
      default:     rdata_o                 = '0;
    endcase
  end

  assign req_o    = req_q;
  assign blksel_o = blksel_q;
  assign lock_o   = lock_q;

  p_blksel_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_blk && erase_active_i) |=> $stable(blksel_q));

  p_retain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !wr_en_i) |=> ($stable(req_q) && $stable(blksel_q)));
endmodule

// File: rtl/flash_prot_err.sv
module flash_prot_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic pe_active_i,
  input  logic viol_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        err_q <= 1'b0;
    else if ((fault_i && pe_active_i) || viol_i)        err_q <= 1'b1;
  end

  assign err_o = err_q;

  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  p_fault_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && pe_active_i) |=> err_q);

  p_viol_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i |=> err_q);
endmodule

// File: rtl/flash_prot_mode.sv
module flash_prot_mode
  import flash_prot_pkg::*;
#(
  parameter int NUM_BLOCKS = 8
) (
  input  req_t                  req_i,
  input  logic                  lock_i,
  input  logic                  err_i,
  input  logic [NUM_BLOCKS-1:0] blksel_i,
  output fmode_e                mode_o,
  output logic                  pe_active_o,
  output logic [NUM_BLOCKS-1:0] blk_en_o
);
  logic pe_req, pe_block;

  assign pe_req   = req_i.prog || req_i.erase;
  assign pe_block = lock_i || err_i || (req_i.prog && req_i.erase);

  always_comb begin
    mode_o = MODE_IDLE;
    if (pe_req) begin
      // verify requests are ignored while a program/erase request is pending
      if (!pe_block) mode_o = req_i.prog ? MODE_PROG : MODE_ERASE;
    end else if (req_i.pver) begin
      mode_o = MODE_PVER;
    end else if (req_i.ever) begin
      mode_o = MODE_EVER;
    end
  end

  assign pe_active_o = (mode_o == MODE_PROG) || (mode_o == MODE_ERASE);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign blk_en_o[b] = blksel_i[b] && (mode_o == MODE_ERASE);
  end
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
  import flash_prot_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic                  fault_i,
  output logic [2:0]            mode_o,
  output logic [NUM_BLOCKS-1:0] blk_erase_en_o,
  output logic                  err_o
);
  req_t                  req;
  logic [NUM_BLOCKS-1:0] blksel;
  logic                  lock, viol, err, pe_active;
  fmode_e                mode;

  flash_prot_regs #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .addr_i         (addr_i),
    .wdata_i        (wdata_i),
    .erase_active_i (mode == MODE_ERASE),
    .err_i          (err),
    .req_o          (req),
    .blksel_o       (blksel),
    .lock_o         (lock),
    .viol_o         (viol),
    .rdata_o        (rdata_o)
  );

  flash_prot_err u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fault_i     (fault_i),
    .pe_active_i (pe_active),
    .viol_i      (viol),
    .err_o       (err)
  );

  flash_prot_mode #(.NUM_BLOCKS(NUM_BLOCKS)) u_mode (
    .req_i       (req),
    .lock_i      (lock),
    .err_i       (err),
    .blksel_i    (blksel),
    .mode_o      (mode),
    .pe_active_o (pe_active),
    .blk_en_o    (blk_erase_en_o)
  );

  assign mode_o = mode;
  assign err_o  = err;

  p_lock_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> (mode_o != MODE_PROG && mode_o != MODE_ERASE));

  p_err_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (mode_o != MODE_PROG && mode_o != MODE_ERASE));

  p_verify_masked_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req.prog || req.erase) |-> (mode_o != MODE_PVER && mode_o != MODE_EVER));

  p_erase_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|blk_erase_en_o) |-> (mode_o == MODE_ERASE));

  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd4);
endmodule

// File: tb/flash_prot_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_prot_ctrl_tb_top;
  localparam int NB = 8;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          fault_i = 1'b0;
  logic [2:0]    mode_o;
  logic [NB-1:0] blk_erase_en_o;
  logic          err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0]    m_req;
  logic [NB-1:0] m_blk;
  logic          m_lock, m_err;

  always #10 clk_i = ~clk_i;

  flash_prot_ctrl #(.NUM_BLOCKS(NB), .DATA_W(DW)) dut_i (.*);

  function automatic logic [2:0] exp_mode(logic [3:0] r, logic lk, logic e);
    if (r[0] || r[1]) begin
      if (lk || e || (r[0] && r[1])) return 3'd0;
      return r[0] ? 3'd1 : 3'd2;
    end
    if (r[2]) return 3'd3;
    if (r[3]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [NB-1:0] exp_en(logic [2:0] m, logic [NB-1:0] b);
    return (m == 3'd2) ? b : '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_req = '0; m_blk = '0; m_lock = 1'b0; m_err = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 1'b0; fault_i = 1'b0;
    model_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [DW-1:0] d, input logic f);
    logic [2:0] cur;
    @(negedge clk_i);
    cur = exp_mode(m_req, m_lock, m_err);
    if (f && (cur == 3'd1 || cur == 3'd2)) m_err = 1'b1;
    if (we) begin
      case (a)
        2'd0: begin m_req = d[3:0]; if (d[0] && d[1]) m_err = 1'b1; end
        2'd1: if (cur == 3'd2) m_err = 1'b1; else m_blk = d[NB-1:0];
        2'd2: m_lock = d[0];
        default: ;
      endcase
    end
    wr_en_i = we; addr_i = a; wdata_i = d; fault_i = f;
    @(negedge clk_i);
    wr_en_i = 1'b0; fault_i = 1'b0;
  endtask

  task automatic chk_state(input string tag);
    logic [2:0] m;
    m = exp_mode(m_req, m_lock, m_err);
    chk({tag, " mode"}, 32'(mode_o), 32'(m));
    chk({tag, " en"}, 32'(blk_erase_en_o), 32'(exp_en(m, m_blk)));
    chk({tag, " err"}, 32'(err_o), 32'(m_err));
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    @(negedge clk_i);
    addr_i = a; wr_en_i = 1'b0;
    #1 v = rdata_o;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'h5eed_0042));
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk_state("R1");
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 rdata", 32'(v), 0); end

    // R2/R6: program with empty erase select
    step(1, 2'd0, 8'h01, 0); chk_state("R6");
    chk("R2 prog", 32'(mode_o), 1);
    // R12: verify masked by program
    step(1, 2'd0, 8'h0D, 0); chk("R12 prog+ver", 32'(mode_o), 1);
    step(1, 2'd0, 8'h00, 0);
    // R5: erase with selection
    step(1, 2'd1, 8'hA5, 0);
    step(1, 2'd0, 8'h02, 0); chk("R5 en", 32'(blk_erase_en_o), 32'hA5); chk_state("R2");
    step(1, 2'd0, 8'h00, 0); chk("R5 idle en", 32'(blk_erase_en_o), 0);
    step(1, 2'd1, 8'h00, 0);
    step(1, 2'd0, 8'h02, 0); chk("R5 zero sel", 32'(blk_erase_en_o), 0); chk("R5 zero mode", 32'(mode_o), 2);
    step(1, 2'd0, 8'h0C, 0); chk("R2 both ver", 32'(mode_o), 3);
    step(1, 2'd0, 8'h08, 0); chk("R2 ever", 32'(mode_o), 4);
    // R7: fault outside program/erase ignored
    step(0, 2'd0, 8'h00, 1); chk("R7 fault in verify", 32'(err_o), 0);
    // R3/R4: lock
    step(1, 2'd1, 8'hFF, 0);
    step(1, 2'd2, 8'h01, 0);
    step(1, 2'd0, 8'h01, 0); chk("R3 prog locked", 32'(mode_o), 0);
    step(1, 2'd0, 8'h02, 0); chk("R3 erase locked", 32'(mode_o), 0); chk("R3 en", 32'(blk_erase_en_o), 0);
    step(1, 2'd0, 8'h06, 0); chk("R12 locked erase+pver", 32'(mode_o), 0);
    step(1, 2'd0, 8'h04, 0); chk("R4 pver", 32'(mode_o), 3);
    step(1, 2'd0, 8'h08, 0); chk("R4 ever", 32'(mode_o), 4);
    step(0, 2'd0, 8'h00, 1); chk("R7 fault locked", 32'(err_o), 0);
    step(1, 2'd2, 8'h00, 0);
    // R7/R9: fault during program
    step(1, 2'd1, 8'h3C, 0);
    step(1, 2'd0, 8'h01, 0); chk("R7 pre", 32'(mode_o), 1);
    step(0, 2'd0, 8'h00, 1); chk("R7 err", 32'(err_o), 1); chk("R7 abort", 32'(mode_o), 0);
    rd(2'd0, v); chk("R9 req kept", 32'(v), 1);
    rd(2'd1, v); chk("R9 sel kept", 32'(v), 32'h3C);
    rd(2'd3, v); chk("R7 status", 32'(v), 1);
    // R11/R10
    step(1, 2'd3, 8'h00, 0); chk("R11 sticky", 32'(err_o), 1);
    step(1, 2'd0, 8'h02, 0); chk("R10 erase blocked", 32'(mode_o), 0);
    step(1, 2'd0, 8'h04, 0); chk("R10 pver", 32'(mode_o), 3);
    step(1, 2'd0, 8'h08, 0); chk("R10 ever", 32'(mode_o), 4);
    do_reset(); @(negedge clk_i); chk("R11 reset clears", 32'(err_o), 0);
    // R8: program+erase together
    step(1, 2'd0, 8'h03, 0); chk("R8 p+e err", 32'(err_o), 1); chk("R8 mode", 32'(mode_o), 0);
    rd(2'd0, v); chk("R9 violating write kept", 32'(v), 3);
    // R8: erase-select write during erase
    do_reset();
    step(1, 2'd1, 8'h0F, 0);
    step(1, 2'd0, 8'h02, 0);
    step(1, 2'd1, 8'hF0, 0); chk("R8 sel mid-erase", 32'(err_o), 1);
    rd(2'd1, v); chk("R8 sel discarded", 32'(v), 32'h0F);
    chk("R8 abort", 32'(mode_o), 0);
    // R7: fault coincident with write ending program
    do_reset();
    step(1, 2'd0, 8'h01, 0);
    step(1, 2'd0, 8'h04, 1); chk("R7 same-cycle", 32'(err_o), 1); chk("R10 ver after", 32'(mode_o), 3);

    // constrained random segments
    for (int s = 0; s < 200; s++) begin
      do_reset();
      for (int i = 0; i < 30; i++) begin
        logic [1:0]    a;
        logic [DW-1:0] d;
        logic          f;
        a = 2'($urandom % 4);
        d = DW'($urandom);
        if (a == 2'd0 && ($urandom % 4) != 0) d[1] = d[1] & ~d[0];
        f = (($urandom % 12) == 0);
        step(($urandom % 4) != 0, a, d, f);
        chk_state("R2 rnd");
        rd(2'd0, v); chk("R9 rnd req", 32'(v), 32'(m_req));
        rd(2'd1, v); chk("R9 rnd sel", 32'(v), 32'(m_blk));
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule